// File: doc/BRIEF.md
# Datapath ALU with Second-Operand Pass Mode

This block is the arithmetic and logic unit of a single-cycle load/store processor datapath. It takes two operands of a parameterised width (64 bits by default) and a 4-bit operation code. From these it forms a result and a zero flag within the same evaluation. It has no clock and no reset. The decoder turns each instruction into an operation code. The branch logic reads the zero flag.

Six operations are defined: bitwise AND, OR and NOR, wrapping addition, wrapping subtraction, and a mode that forwards the second operand unchanged. The forwarding mode lets a compare-against-zero branch test a register value directly through the zero flag. Every other code gives an all-zero result.

Two parameters pick how the adder and the zero detector are built. The adder can be a single flat carry chain or a segmented carry-select structure. The zero detector reduces the result in chunks of a chosen size. The function at the ports is the same for every choice.

Top module: `dp_alu`

## Requirements
- R1: Code 4'b0000 gives the bitwise AND of `opnd_a` and `opnd_b` on `result`.
- R2: Code 4'b0001 gives the bitwise OR of `opnd_a` and `opnd_b`.
- R3: Code 4'b0010 gives `opnd_a + opnd_b` modulo 2^DATA_W; a carry out of the top bit is discarded.
- R4: Code 4'b0110 gives `opnd_a - opnd_b`, formed as `opnd_a + ~opnd_b + 1` modulo 2^DATA_W, with no overflow indication.
- R5: Code 4'b0111 copies `opnd_b` to `result`; `opnd_a` has no effect in this mode.
- R6: Code 4'b1100 gives the bitwise NOR of `opnd_a` and `opnd_b`.
- R7: Any of the ten remaining codes gives a `result` of all zeros, whatever the operands are.
- R8: `zero` is 1 exactly when every bit of `result` is 0, for every code, including the unused codes.
- R9: The outputs follow the inputs combinationally; no clock edge is needed for a new result to appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 4 | Operation select |
| opnd_a | input | DATA_W | First operand |
| opnd_b | input | DATA_W | Second operand |
| result | output | DATA_W | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
Each logic operation is tried with complementary checkerboard operands and with overlapping patterns, so that AND, OR and NOR give results that differ from each other and from the operands. Addition and subtraction are tried with a carry that ripples across the whole word, with a wrap past the top, and with a borrow below zero. These cases separate a true wrapping adder from one that drops segment carries or the subtract carry-in. The forwarding mode is given two different first operands with one fixed second operand, which shows that the first operand has no effect. The zero flag is checked on results that are zero only because of wrap, equal-operand subtraction, a forwarded zero and the unused codes.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

   typedef enum logic [3:0] {
      OP_AND   = 4'b0000,
      OP_OR    = 4'b0001,
      OP_ADD   = 4'b0010,
      OP_SUB   = 4'b0110,
      OP_PASSB = 4'b0111,
      OP_NOR   = 4'b1100
   } alu_op_e;

   localparam int unsigned OP_W = 4;

   // adder build variants
   localparam int unsigned ADD_FLAT   = 0;
   localparam int unsigned ADD_CSELECT = 1;

endpackage

// File: rtl/dp_alu_bitwise.sv
module dp_alu_bitwise #(
   parameter int unsigned DATA_W = 64
) (
   input  logic [DATA_W-1:0] lhs,
   input  logic [DATA_W-1:0] rhs,
   output logic [DATA_W-1:0] and_v,
   output logic [DATA_W-1:0] or_v,
   output logic [DATA_W-1:0] nor_v
);

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         assign and_v[i] = lhs[i] & rhs[i];
         assign or_v[i]  = lhs[i] | rhs[i];
         assign nor_v[i] = ~(lhs[i] | rhs[i]);
      end
   endgenerate

endmodule

// File: rtl/dp_alu_addsub.sv
module dp_alu_addsub #(
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned ADD_STYLE = 1,
   parameter int unsigned SEG_W     = 16
) (
   input  logic              subtract,
   input  logic [DATA_W-1:0] lhs,
   input  logic [DATA_W-1:0] rhs,
   output logic [DATA_W-1:0] sum
);

   logic [DATA_W-1:0] rhs_eff;

   assign rhs_eff = subtract ? ~rhs : rhs;

   generate
      if (ADD_STYLE == dp_alu_pkg::ADD_FLAT) begin : g_flat
         assign sum = lhs + rhs_eff + {{(DATA_W-1){1'b0}}, subtract};
      end else begin : g_csel
         localparam int unsigned NSEG = DATA_W / SEG_W;

         if (DATA_W % SEG_W != 0) begin : g_bad_seg
            $error("dp_alu_addsub: DATA_W must be a multiple of SEG_W");
         end

         logic [NSEG:0] seg_cy;
         assign seg_cy[0] = subtract;

         for (genvar s = 0; s < NSEG; s++) begin : g_seg
            logic [SEG_W:0] pre0;
            logic [SEG_W:0] pre1;
            assign pre0 = {1'b0, lhs[s*SEG_W +: SEG_W]} + {1'b0, rhs_eff[s*SEG_W +: SEG_W]};
            assign pre1 = {1'b0, lhs[s*SEG_W +: SEG_W]} + {1'b0, rhs_eff[s*SEG_W +: SEG_W]}
                          + {{SEG_W{1'b0}}, 1'b1};
            assign sum[s*SEG_W +: SEG_W] = seg_cy[s] ? pre1[SEG_W-1:0] : pre0[SEG_W-1:0];
            assign seg_cy[s+1]           = seg_cy[s] ? pre1[SEG_W] : pre0[SEG_W];
         end
      end
   endgenerate

endmodule

// File: rtl/dp_alu_zero_det.sv
module dp_alu_zero_det #(
   parameter int unsigned DATA_W  = 64,
   parameter int unsigned CHUNK_W = 8
) (
   input  logic [DATA_W-1:0] vec,
   output logic              all_clear
);

   localparam int unsigned NCHUNK = (DATA_W + CHUNK_W - 1) / CHUNK_W;
   localparam int unsigned PAD_W  = NCHUNK * CHUNK_W;

   logic [PAD_W-1:0]  padded;
   logic [NCHUNK-1:0] chunk_hot;

   assign padded = PAD_W'(vec);

   generate
      for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
         assign chunk_hot[c] = |padded[c*CHUNK_W +: CHUNK_W];
      end
   endgenerate

   assign all_clear = ~|chunk_hot;

endmodule

// File: rtl/dp_alu.sv
module dp_alu #(
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned ADD_STYLE = 1,
   parameter int unsigned SEG_W     = 16,
   parameter int unsigned CHUNK_W   = 8
) (
   input  logic [3:0]        op_code,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   output logic [DATA_W-1:0] result,
   output logic              zero
);

   import dp_alu_pkg::*;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("dp_alu: DATA_W must be at least 2");
      end
      if (ADD_STYLE > ADD_CSELECT) begin : g_bad_style
         $error("dp_alu: unknown ADD_STYLE");
      end
      if (CHUNK_W == 0 || SEG_W == 0) begin : g_bad_grain
         $error("dp_alu: CHUNK_W and SEG_W must be non-zero");
      end
   endgenerate

   logic [DATA_W-1:0] and_v;
   logic [DATA_W-1:0] or_v;
   logic [DATA_W-1:0] nor_v;
   logic [DATA_W-1:0] arith_v;
   logic              do_sub;

   assign do_sub = (op_code == OP_SUB);

   dp_alu_bitwise #(.DATA_W(DATA_W)) u_bitwise (
      .lhs   (opnd_a),
      .rhs   (opnd_b),
      .and_v (and_v),
      .or_v  (or_v),
      .nor_v (nor_v)
   );

   dp_alu_addsub #(
      .DATA_W    (DATA_W),
      .ADD_STYLE (ADD_STYLE),
      .SEG_W     (SEG_W)
   ) u_addsub (
      .subtract (do_sub),
      .lhs      (opnd_a),
      .rhs      (opnd_b),
      .sum      (arith_v)
   );

   always_comb begin
      unique case (op_code)
         OP_AND:   result = and_v;
         OP_OR:    result = or_v;
         OP_ADD:   result = arith_v;
         OP_SUB:   result = arith_v;
         OP_PASSB: result = opnd_b;
         OP_NOR:   result = nor_v;
         default:  result = '0;
      endcase
   end

   dp_alu_zero_det #(
      .DATA_W  (DATA_W),
      .CHUNK_W (CHUNK_W)
   ) u_zero (
      .vec       (result),
      .all_clear (zero)
   );

   // checks on the assembled outputs
   always_comb begin
      if (op_code == OP_AND)
         p_and_subset_r1: assert (((result & ~opnd_a) | (result & ~opnd_b)) == '0)
            else $error("AND result has bits outside an operand");
      if (op_code == OP_OR)
         p_or_cover_r2: assert ((result & (opnd_a | opnd_b)) == (opnd_a | opnd_b))
            else $error("OR result misses an operand bit");
      if (op_code == OP_ADD)
         p_add_inverse_r3: assert (result - opnd_b == opnd_a)
            else $error("ADD result inconsistent with operands");
      if (op_code == OP_SUB)
         p_sub_inverse_r4: assert (result + opnd_b == opnd_a)
            else $error("SUB result inconsistent with operands");
      if (op_code == OP_PASSB)
         p_passb_copy_r5: assert (result == opnd_b)
            else $error("pass mode does not forward second operand");
      if (op_code == OP_NOR)
         p_nor_disjoint_r6: assert ((result & (opnd_a | opnd_b)) == '0)
            else $error("NOR result overlaps an operand bit");
      if (!(op_code inside {OP_AND, OP_OR, OP_ADD, OP_SUB, OP_PASSB, OP_NOR}))
         p_unused_clear_r7: assert (result == '0)
            else $error("unused code produced non-zero result");
      p_zero_flag_r8: assert (zero == (result == '0))
         else $error("zero flag disagrees with result");
   end

endmodule

// File: tb/dp_alu_bench.sv
module dp_alu_bench;

   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned W          = 64;

   logic         clk = 1'b0;
   logic [3:0]   op_code;
   logic [W-1:0] opnd_a;
   logic [W-1:0] opnd_b;
   logic [W-1:0] result;
   logic         zero;

   int total = 0;
   int bad   = 0;

   localparam logic [W-1:0] ONES = {W{1'b1}};
   localparam logic [W-1:0] CHK  = {(W/2){2'b10}};

   always #(CLK_PERIOD/2) clk = ~clk;

   dp_alu u_dp_alu (
      .op_code (op_code),
      .opnd_a  (opnd_a),
      .opnd_b  (opnd_b),
      .result  (result),
      .zero    (zero)
   );

   task automatic apply(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
      @(posedge clk);
      op_code = op;
      opnd_a  = a;
      opnd_b  = b;
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [W-1:0] exp_res);
      logic exp_z;
      exp_z = (exp_res == '0);
      total++;
      if (result !== exp_res || zero !== exp_z) begin
         bad++;
         $display("FAIL %s op=%b result=%h zero=%b expected result=%h zero=%b",
                  req, op_code, result, zero, exp_res, exp_z);
      end
   endtask

   task automatic t_idle;   // R9, R8: all-zero inputs settle without a clock edge
      op_code = 4'b0000; opnd_a = '0; opnd_b = '0;
      #1;
      check("R9", '0);
      opnd_a = ONES; opnd_b = CHK;
      #1;
      check("R9", CHK);
   endtask

   task automatic t_and;
      apply(4'b0000, CHK, ~CHK);                  check("R1", '0);
      apply(4'b0000, 64'hF0F0_1234_FFFF_0000, 64'hFF00_FFFF_0F0F_FFFF);
      check("R1", 64'hF0F0_1234_FFFF_0000 & 64'hFF00_FFFF_0F0F_FFFF);
   endtask

   task automatic t_or;
      apply(4'b0001, CHK, ~CHK);                  check("R2", ONES);
      apply(4'b0001, 64'h0000_00A0_0000_0001, 64'h8000_000A_0000_0000);
      check("R2", 64'h8000_00AA_0000_0001);
   endtask

   task automatic t_add;
      apply(4'b0010, 64'h0000_0000_FFFF_FFFF, 64'd1);  check("R3", 64'h0000_0001_0000_0000);
      apply(4'b0010, ONES, 64'd1);                     check("R3", '0);
      apply(4'b0010, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1);  check("R3", 64'h8000_0000_0000_0000);
      apply(4'b0010, 64'd123456789, 64'd987654321);    check("R3", 64'd1111111110);
   endtask

   task automatic t_sub;
      apply(4'b0110, 64'd0, 64'd1);                    check("R4", ONES);
      apply(4'b0110, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0); check("R4", '0);
      apply(4'b0110, 64'h0001_0000_0000_0000, 64'd1);  check("R4", 64'h0000_FFFF_FFFF_FFFF);
      apply(4'b0110, 64'd1000, 64'd58);                check("R4", 64'd942);
   endtask

   task automatic t_pass;
      apply(4'b0111, ONES, 64'h0BAD_F00D_0000_0042);   check("R5", 64'h0BAD_F00D_0000_0042);
      apply(4'b0111, '0,   64'h0BAD_F00D_0000_0042);   check("R5", 64'h0BAD_F00D_0000_0042);
      apply(4'b0111, ONES, '0);                        check("R5", '0);
   endtask

   task automatic t_nor;
      apply(4'b1100, '0, '0);                          check("R6", ONES);
      apply(4'b1100, CHK, ~CHK);                       check("R6", '0);
      apply(4'b1100, 64'h00FF_0000_0000_0000, 64'h0000_0000_0000_F00F);
      check("R6", ~(64'h00FF_0000_0000_F00F));
   endtask

   task automatic t_unused;   // R7 and R8 over every code outside the six
      for (int c = 0; c < 16; c++) begin
         if (!(c inside {0, 1, 2, 6, 7, 12})) begin
            apply(4'(c), ONES, CHK);
            check("R7", '0);
         end
      end
   endtask

   task automatic t_zero_flag;   // R8: zero only when every result bit clear
      apply(4'b0111, '0, 64'h8000_0000_0000_0000);     check("R8", 64'h8000_0000_0000_0000);
      apply(4'b0111, '0, 64'd1);                       check("R8", 64'd1);
      apply(4'b0010, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000); check("R8", '0);
      apply(4'b0000, ONES, '0);                        check("R8", '0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_idle();
      t_and();
      t_or();
      t_add();
      t_sub();
      t_pass();
      t_nor();
      t_unused();
      t_zero_flag();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule